// File: doc/BRIEF.md
# Interlocked Read Link over a Shared Address/Data Bus

This block joins a device-side requester and a memory-side responder through three control wires and one shared word-wide bus. A read goes through two fully interlocked four-edge exchanges. In the first exchange the requester puts an address on the bus and asks for a read. In the second exchange the responder puts the word it fetched on the same bus. Each side sees the other side's control wires only through a two-stage synchronizer. Each side also waits a fixed number of cycles per protocol step, which stands for the wire and logic delay of one handshake.

The responder contains a memory model whose access time is a parameter. The access starts on the cycle the address is captured, so it runs while the requester is still letting go of the bus and while the responder is still clearing its address acknowledge. The returned word is only offered after both the access and the address exchange have finished. The local side starts a read with a one-cycle `start_i` while `busy_o` is low. It gets the word back with a one-cycle `done_o`.

Top module: `rdshake_link`

## Requirements
- R1: While reset is held and just after it is released, `read_req_o`, `ack_o`, `data_rdy_o`, `done_o` and `busy_o` are low and `bus_o` is zero.
- R2: `start_i` is taken only when `busy_o` is low. A start pulse given while `busy_o` is high produces no transaction and no `done_o` pulse.
- R3: While `read_req_o` is high, `bus_o` carries the requested address. `read_req_o` falls only while `ack_o` is high. The responder's address acknowledge falls only after `read_req_o` is low and the requester has stopped driving.
- R4: The returned word is the bitwise complement of the captured address. It is on `bus_o` whenever `data_rdy_o` is high, and it is the value presented on `rdata_o`.
- R5: `data_rdy_o` rises only when `read_req_o` and `ack_o` are both low and the access has finished. It falls only while the requester's data acknowledge is high.
- R6: The access overlaps the address exchange. The number of cycles from the cycle `start_i` is applied to the cycle `done_o` is seen is greater than `ACC_CYC` and smaller than `ACC_CYC + 6*(STEP_CYC+2)`.
- R7: At most one party drives the bus at any time. While `busy_o` is low the bus reads zero.
- R8: `done_o` lasts exactly one cycle, and all three control wires are low in that cycle.
- R9: Every reaction to a remote control edge takes exactly `STEP_CYC+2` cycles: two synchronizer stages plus the step delay. This is seen, for example, from the rise of `read_req_o` to the rise of `ack_o`, and from that rise of `ack_o` to the fall of `read_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both endpoints |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to read `addr_i` |
| addr_i | input | W | Address for a new read |
| busy_o | output | 1 | High while a read is in flight or any control wire is high |
| done_o | output | 1 | One-cycle pulse when `rdata_o` holds the fetched word |
| rdata_o | output | W | Word captured by the requester |
| read_req_o | output | 1 | Requester's read request wire |
| ack_o | output | 1 | Acknowledge wire, raised by whichever side is acknowledging |
| data_rdy_o | output | 1 | Responder's data-ready wire |
| bus_o | output | W | Shared address/data bus value |

## Verification
A scoreboard holds the expected complement words. The bench looks for a word that is lost, duplicated or corrupted, which is what a design would show if it acted on a start pulse given mid-transaction or latched the bus before the data was driven. It times the reaction edges exactly, so a missing synchronizer stage or a step count that is off by one shows up as a wrong cycle count. The latency bound catches a responder that waits for the address exchange to finish before starting its access. The all-zeros and all-ones addresses, and reads issued back to back, check that the bus hand-over never overlaps and that a new request never starts while an acknowledge from the previous read is still high.

// File: rtl/rdshake_link.sv
module rdshake_link #(
  parameter int W        = 16,
  parameter int STEP_CYC = 4,
  parameter int ACC_CYC  = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] addr_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rdata_o,
  output logic         read_req_o,
  output logic         ack_o,
  output logic         data_rdy_o,
  output logic [W-1:0] bus_o
);

  localparam int SW = $clog2(STEP_CYC + 1);
  localparam int AW = $clog2(ACC_CYC + 1);
  localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYC - 1);
  localparam logic [AW-1:0] ACC_LOAD  = AW'(ACC_CYC);

  typedef enum logic [2:0] {Q_IDLE, Q_SETUP, Q_WAIT_ACK, Q_WAIT_DATA, Q_WAIT_DROP} q_t;
  typedef enum logic [2:0] {M_IDLE, M_HOLD_ACK, M_ACCESS, M_DRIVE, M_WAIT_ACK, M_WAIT_REL} m_t;

  q_t          q_st;
  logic [SW-1:0] q_cnt;
  logic [W-1:0]  q_addr, q_data;
  logic        q_req, q_ack, q_drv, q_done;
  logic [1:0]  q_ack_s, q_rdy_s;
  logic        q_cond, q_fire;

  m_t          m_st;
  logic [SW-1:0] m_cnt;
  logic [AW-1:0] m_acc;
  logic [W-1:0]  m_word;
  logic        m_ack, m_rdy, m_drv;
  logic [1:0]  m_req_s, m_ack_s;
  logic        m_cond, m_fire;

  logic         ack_line;
  logic [W-1:0] bus;

  assign ack_line   = q_ack | m_ack;
  assign bus        = q_drv ? q_addr : (m_drv ? m_word : '0);
  assign bus_o      = bus;
  assign read_req_o = q_req;
  assign ack_o      = ack_line;
  assign data_rdy_o = m_rdy;
  assign rdata_o    = q_data;
  assign done_o     = q_done;
  assign busy_o     = (q_st != Q_IDLE) || (m_st != M_IDLE) || q_req || ack_line || m_rdy;

  // requester side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_ack_s <= '0;
      q_rdy_s <= '0;
    end else begin
      q_ack_s <= {q_ack_s[0], ack_line};
      q_rdy_s <= {q_rdy_s[0], m_rdy};
    end
  end

  always_comb begin
    case (q_st)
      Q_SETUP:     q_cond = 1'b1;
      Q_WAIT_ACK:  q_cond = q_ack_s[1];
      Q_WAIT_DATA: q_cond = q_rdy_s[1];
      Q_WAIT_DROP: q_cond = !q_rdy_s[1];
      default:     q_cond = 1'b0;
    endcase
  end
  assign q_fire = q_cond && (q_cnt == STEP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_st   <= Q_IDLE;
      q_cnt  <= '0;
      q_addr <= '0;
      q_data <= '0;
      q_req  <= 1'b0;
      q_ack  <= 1'b0;
      q_drv  <= 1'b0;
      q_done <= 1'b0;
    end else begin
      q_done <= 1'b0;
      q_cnt  <= (q_cond && !q_fire) ? q_cnt + 1'b1 : '0;
      case (q_st)
        Q_IDLE: if (start_i && !busy_o) begin
          q_addr <= addr_i;
          q_drv  <= 1'b1;
          q_st   <= Q_SETUP;
        end
        Q_SETUP: if (q_fire) begin
          q_req <= 1'b1;
          q_st  <= Q_WAIT_ACK;
        end
        Q_WAIT_ACK: if (q_fire) begin
          q_req <= 1'b0;
          q_drv <= 1'b0;
          q_st  <= Q_WAIT_DATA;
        end
        Q_WAIT_DATA: if (q_fire) begin
          q_data <= bus;
          q_ack  <= 1'b1;
          q_st   <= Q_WAIT_DROP;
        end
        Q_WAIT_DROP: if (q_fire) begin
          q_ack  <= 1'b0;
          q_done <= 1'b1;
          q_st   <= Q_IDLE;
        end
        default: q_st <= Q_IDLE;
      endcase
    end
  end

  // responder side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req_s <= '0;
      m_ack_s <= '0;
    end else begin
      m_req_s <= {m_req_s[0], q_req};
      m_ack_s <= {m_ack_s[0], ack_line};
    end
  end

  always_comb begin
    case (m_st)
      M_IDLE:     m_cond = m_req_s[1];
      M_HOLD_ACK: m_cond = !m_req_s[1];
      M_ACCESS:   m_cond = (m_acc == '0);
      M_DRIVE:    m_cond = 1'b1;
      M_WAIT_ACK: m_cond = m_ack_s[1];
      M_WAIT_REL: m_cond = !m_ack_s[1];
      default:    m_cond = 1'b0;
    endcase
  end
  assign m_fire = m_cond && ((m_st == M_ACCESS) || (m_st == M_WAIT_REL) || (m_cnt == STEP_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st   <= M_IDLE;
      m_cnt  <= '0;
      m_acc  <= '0;
      m_word <= '0;
      m_ack  <= 1'b0;
      m_rdy  <= 1'b0;
      m_drv  <= 1'b0;
    end else begin
      m_cnt <= (m_cond && !m_fire) ? m_cnt + 1'b1 : '0;
      if (m_acc != '0) m_acc <= m_acc - 1'b1;
      case (m_st)
        M_IDLE: if (m_fire) begin
          m_word <= ~bus;
          m_acc  <= ACC_LOAD;
          m_ack  <= 1'b1;
          m_st   <= M_HOLD_ACK;
        end
        M_HOLD_ACK: if (m_fire) begin
          m_ack <= 1'b0;
          m_st  <= M_ACCESS;
        end
        M_ACCESS: if (m_fire) begin
          m_drv <= 1'b1;
          m_st  <= M_DRIVE;
        end
        M_DRIVE: if (m_fire) begin
          m_rdy <= 1'b1;
          m_st  <= M_WAIT_ACK;
        end
        M_WAIT_ACK: if (m_fire) begin
          m_rdy <= 1'b0;
          m_drv <= 1'b0;
          m_st  <= M_WAIT_REL;
        end
        M_WAIT_REL: if (m_fire) m_st <= M_IDLE;
        default: m_st <= M_IDLE;
      endcase
    end
  end

  p_single_driver_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_drv && m_drv));
  p_ack_answers_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_ack) |-> q_req);
  p_req_drops_on_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_req) |-> m_ack);
  p_ack_drops_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m_ack) |-> (!q_req && !q_drv));
  p_rdy_after_addr_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_rdy) |-> (!q_req && !ack_line && m_acc == '0));
  p_rdy_drops_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m_rdy) |-> q_ack);
  p_capture_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_ack) |-> (q_data == m_word));
  p_done_lines_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_done |-> (!q_req && !m_rdy && !ack_line));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_done |=> !q_done);

endmodule

// File: tb/rdshake_link_tb.sv
module rdshake_link_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int S = 4;
  localparam int A = 20;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, start_i, busy_o, done_o, read_req_o, ack_o, data_rdy_o;
  logic [W-1:0] addr_i, rdata_o, bus_o;

  rdshake_link #(.W(W), .STEP_CYC(S), .ACC_CYC(A)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .read_req_o(read_req_o), .ack_o(ack_o), .data_rdy_o(data_rdy_o), .bus_o(bus_o));

  int checks = 0, errors = 0, cyc = 0, n_issued = 0, n_done = 0;
  logic [W-1:0] exp_q[$];
  int start_q[$];
  logic [W-1:0] cur_addr = '0;
  bit mon_on = 0, finished = 0;
  bit p_req = 0, p_ack = 0, p_rdy = 0, p_done = 0, want_ack = 0, want_fall = 0;
  int t_req = 0, t_ack = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [W-1:0] a);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    start_i = 1'b1;
    addr_i = a;
    cur_addr = a;
    exp_q.push_back(~a);
    start_q.push_back(cyc);
    n_issued++;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy_o || exp_q.size() != 0);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (p_done) chk(!done_o, "R8 done pulse width", done_o, 0);
      if (done_o) begin
        n_done++;
        chk(!read_req_o && !ack_o && !data_rdy_o, "R8 lines low at done",
            {read_req_o, ack_o, data_rdy_o}, 0);
        if (exp_q.size() == 0) chk(0, "R2 unexpected done", 1, 0);
        else begin
          logic [W-1:0] e;
          int lat;
          e = exp_q.pop_front();
          lat = cyc - start_q.pop_front();
          chk(rdata_o == e, "R4 returned word", rdata_o, e);
          chk(lat > A && lat < A + 6*(S+2), "R6 overlapped latency", lat, A + 6*(S+2) - 2);
        end
      end
      if (read_req_o && !p_req) begin t_req = cyc; want_ack = 1; end
      if (read_req_o && !p_req) chk(bus_o == cur_addr, "R3 address on bus", bus_o, cur_addr);
      if (ack_o && !p_ack && want_ack) begin
        chk(cyc - t_req == S + 2, "R9 req to ack", cyc - t_req, S + 2);
        t_ack = cyc; want_ack = 0; want_fall = 1;
      end
      if (!read_req_o && p_req && want_fall) begin
        chk(cyc - t_ack == S + 2, "R9 ack to req drop", cyc - t_ack, S + 2);
        chk(ack_o, "R3 req drops with ack high", ack_o, 1);
        want_fall = 0;
      end
      if (data_rdy_o && !p_rdy) begin
        chk(!read_req_o && !ack_o, "R5 ready after address phase", {read_req_o, ack_o}, 0);
        chk(bus_o == ~cur_addr, "R4 word on bus", bus_o, ~cur_addr);
      end
      if (!data_rdy_o && p_rdy) chk(ack_o, "R5 ready drops on ack", ack_o, 1);
      if (!busy_o) chk(bus_o == '0, "R7 idle bus zero", bus_o, 0);
      p_req = read_req_o; p_ack = ack_o; p_rdy = data_rdy_o; p_done = done_o;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", n_done, n_issued);
    summary();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; addr_i = '0;
    repeat (3) @(negedge clk);
    chk(!read_req_o && !ack_o && !data_rdy_o && !done_o && !busy_o && bus_o == '0,
        "R1 in reset", {read_req_o, ack_o, data_rdy_o, done_o, busy_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!read_req_o && !ack_o && !data_rdy_o && !done_o && !busy_o && bus_o == '0,
        "R1 after reset", {read_req_o, ack_o, data_rdy_o, done_o, busy_o}, 0);
    mon_on = 1;

    do_read(16'h1234); wait_idle();
    do_read(16'h0000); wait_idle();
    do_read(16'hFFFF); wait_idle();

    do_read(16'hA5C3);
    repeat (10) @(negedge clk);
    chk(busy_o, "R2 busy mid read", busy_o, 1);
    start_i = 1'b1; addr_i = 16'h0F0F;
    @(negedge clk);
    start_i = 1'b0;
    repeat (25) @(negedge clk);
    start_i = 1'b1; addr_i = 16'h3C3C;
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    repeat (5) @(negedge clk);
    chk(!busy_o && !read_req_o, "R2 ignored start left link idle", busy_o, 0);

    do_read(16'h8001);
    do_read(16'h7FFE);
    wait_idle();
    repeat (5) @(negedge clk);

    chk(n_done == n_issued, "R2 one done per accepted start", n_done, n_issued);
    chk(exp_q.size() == 0, "R4 no word lost", exp_q.size(), 0);
    summary();
  end
endmodule